// File: doc/BRIEF.md
# Directory Cache Node for One Shared Line

This block is one node in a tree of caches that keeps a single shared line coherent through a directory. The node holds a local copy of the line's value and a coherence state made of two parts: a horizontal part that says whether the node holds the line shared or exclusive among its siblings, and a vertical part that says which of its four children hold copies and in what mode. The vertical part is either read mode, with a 4-bit sharer mask, or write mode, with the id of the one child that owns the line.

Messages arrive through a 4-entry input FIFO and leave through a 4-entry output FIFO, both with valid/ready handshakes. At most one message is handled and at most one is produced per clock. Child read and write misses are answered directly when the local state allows it. Otherwise the node asks the owning child to write back, or forwards an exclusive request to its parent, and keeps the pending requester in a single transaction record until the reply arrives. A request that arrives while the record is busy waits in a one-entry park slot, so that replies behind it can still pass.

Top module: `hcn_node`

## Requirements
- R1: After reset the node is shared horizontally (h_ex_o=0), in read mode (v_wr_o=0) with an empty sharer mask, value 0, owner 0, record idle (busy_o=0) and no output message.
- R2: Opcode encoding is sh-req=0, ex-req=1, wb-req=2, wb-rep=3, sh-rep=4, ex-rep=5. Children use ids 0 to 3 and the parent uses id 4. A sh-req from child c in read mode yields a sh-rep to c carrying the current value and sets bit c of the sharer mask.
- R3: An ex-req from a child while the node is horizontally shared is forwarded as an ex-req to the parent (id 4) and makes the record busy. The parent's ex-rep then makes the node exclusive, stores its data, sends an ex-rep with that data to the recorded child, and puts the node in write mode owned by that child.
- R4: An ex-req from child c while the node is exclusive and in read mode yields an ex-rep to c with the current value, write mode owned by c, and an empty sharer mask.
- R5: A sh-req or ex-req from a child while another child k owns the line in write mode sends a wb-req to k and makes the record busy.
- R6: A wb-rep from the owner k that completes a pending sh-req sends a sh-rep with the written-back data to the requester, stores the data, and leaves read mode with exactly bits k and requester in the mask.
- R7: A wb-rep from the owner that completes a pending ex-req sends an ex-rep with the written-back data to the requester, stores the data, and makes the requester the new owner.
- R8: A wb-req from the parent in read mode is answered with a wb-rep carrying the value, and the node becomes shared. In write mode it is first passed down as a wb-req to the owner k. The owner's wb-rep is then relayed up to the parent, the node stores the data, becomes shared, and keeps k as the only sharer.
- R9: A request that arrives while the record is busy produces no message and changes no state until the record clears. It is then served before any newer message.
- R10: A message whose address is not the node's line or whose destination is not the node's id, a wb-rep not from the current owner during a pending transaction, and an ex-rep or sh-rep that matches no pending forward are all consumed with no output and no state change.
- R11: When the output is held not ready, messages are buffered without loss or reordering, and every produced message appears exactly once in production order.
- R12: Every output message carries the node's own id (5) as source and the line address (0x40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Incoming message valid |
| in_ready_o | output | 1 | Input FIFO has room |
| in_opc_i | input | 3 | Incoming opcode |
| in_src_i | input | 3 | Incoming source id |
| in_dst_i | input | 3 | Incoming destination id |
| in_addr_i | input | ADDR_W | Incoming line address |
| in_data_i | input | DATA_W | Incoming data |
| out_valid_o | output | 1 | Outgoing message valid |
| out_ready_i | input | 1 | Receiver accepts outgoing message |
| out_opc_o | output | 3 | Outgoing opcode |
| out_src_o | output | 3 | Outgoing source id (node id) |
| out_dst_o | output | 3 | Outgoing destination id |
| out_addr_o | output | ADDR_W | Outgoing line address |
| out_data_o | output | DATA_W | Outgoing data |
| h_ex_o | output | 1 | Horizontal state: 1 exclusive, 0 shared |
| v_wr_o | output | 1 | Vertical state: 1 write mode, 0 read mode |
| dir_o | output | N_CHILD | Sharer mask in read mode |
| owner_o | output | 2 | Owning child in write mode |
| value_o | output | DATA_W | Local copy of the line |
| busy_o | output | 1 | Transaction record holds a pending request |

## Verification
The main function is driven through several sequences. Read misses in read mode tell a direct answer apart from a recall. A write miss while shared tells a forward to the parent apart from a local grant. Read and write misses against an owning child separate the two completions of a recall. Parent recalls are tried in both vertical modes, so that the direct answer and the relayed answer are told apart. A request parked behind a busy record shows ordering, because its recall must come right after the grant that released it. Foreign-address, misrouted and stray replies show that such messages are ignored. A burst with the output held stalled shows that no message is lost or reordered.

// File: rtl/hcn_node_pkg.sv
package hcn_node_pkg;
  typedef enum logic [2:0] {
    OP_SH_REQ = 3'd0,
    OP_EX_REQ = 3'd1,
    OP_WB_REQ = 3'd2,
    OP_WB_REP = 3'd3,
    OP_SH_REP = 3'd4,
    OP_EX_REP = 3'd5
  } opc_e;

  typedef enum logic [1:0] {
    RQ_SH = 2'd0,
    RQ_EX = 2'd1,
    RQ_WB = 2'd2
  } rq_e;
endpackage

// File: rtl/hcn_msg_fifo.sv
module hcn_msg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end
endmodule

// File: rtl/hcn_coh_engine.sv
module hcn_coh_engine
  import hcn_node_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                N_CHILD   = 4,
  parameter logic [ADDR_W-1:0] LINE_ADDR = 'h40,
  parameter int                NODE_ID   = 5,
  localparam int               CID_W     = $clog2(N_CHILD),
  localparam int               ID_W      = CID_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_v_i,
  input  logic [2:0]        head_opc_i,
  input  logic [ID_W-1:0]   head_src_i,
  input  logic [ID_W-1:0]   head_dst_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic [DATA_W-1:0] head_data_i,
  output logic              pop_o,
  input  logic              out_full_i,
  output logic              push_o,
  output logic [2:0]        out_opc_o,
  output logic [ID_W-1:0]   out_dst_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              h_ex_o,
  output logic              v_wr_o,
  output logic [N_CHILD-1:0] dir_o,
  output logic [CID_W-1:0]  owner_o,
  output logic [DATA_W-1:0] value_o,
  output logic              busy_o
);
  localparam logic [ID_W-1:0] PARENT = ID_W'(N_CHILD);

  logic               h_ex_q, h_ex_d, v_wr_q, v_wr_d, busy_q, busy_d;
  logic [N_CHILD-1:0] dir_q, dir_d;
  logic [CID_W-1:0]   owner_q, owner_d;
  logic [DATA_W-1:0]  value_q, value_d;
  rq_e                rq_type_q, rq_type_d;
  logic [ID_W-1:0]    rq_id_q, rq_id_d;
  logic               park_v_q, park_v_d;
  logic [2:0]         park_opc_q, park_opc_d;
  logic [ID_W-1:0]    park_src_q, park_src_d;

  logic              use_park, cur_v, cur_ok, go, take, is_child;
  logic [2:0]        cur_opc;
  logic [ID_W-1:0]   cur_src;
  logic [CID_W-1:0]  cid;

  assign use_park = park_v_q && !busy_q;
  assign cur_v    = use_park || head_v_i;
  assign cur_opc  = use_park ? park_opc_q : head_opc_i;
  assign cur_src  = use_park ? park_src_q : head_src_i;
  assign cur_ok   = use_park || (head_addr_i == LINE_ADDR && head_dst_i == ID_W'(NODE_ID));
  assign go       = cur_v && !out_full_i;
  assign is_child = (cur_src < PARENT);
  assign cid      = cur_src[CID_W-1:0];

  always_comb begin
    h_ex_d = h_ex_q;  v_wr_d = v_wr_q;  busy_d = busy_q;
    dir_d = dir_q;    owner_d = owner_q; value_d = value_q;
    rq_type_d = rq_type_q; rq_id_d = rq_id_q;
    park_v_d = park_v_q; park_opc_d = park_opc_q; park_src_d = park_src_q;
    pop_o = 1'b0; push_o = 1'b0; take = 1'b1;
    out_opc_o = OP_SH_REP; out_dst_o = '0; out_data_o = value_q;
    if (go) begin
      if (use_park) park_v_d = 1'b0;
      if (cur_ok) begin
        case (cur_opc)
          OP_SH_REQ, OP_EX_REQ, OP_WB_REQ: begin
            if (busy_q) begin
              // one parked request lets replies behind it pass
              if (park_v_q) take = 1'b0;
              else begin
                park_v_d = 1'b1; park_opc_d = cur_opc; park_src_d = cur_src;
              end
            end else if (cur_opc == OP_WB_REQ) begin
              if (cur_src == PARENT) begin
                push_o = 1'b1;
                if (v_wr_q) begin
                  out_opc_o = OP_WB_REQ; out_dst_o = {1'b0, owner_q};
                  busy_d = 1'b1; rq_type_d = RQ_WB; rq_id_d = PARENT;
                end else begin
                  out_opc_o = OP_WB_REP; out_dst_o = PARENT; h_ex_d = 1'b0;
                end
              end
            end else if (is_child) begin
              push_o = 1'b1;
              if (v_wr_q) begin
                out_opc_o = OP_WB_REQ; out_dst_o = {1'b0, owner_q};
                busy_d = 1'b1; rq_id_d = cur_src;
                rq_type_d = (cur_opc == OP_SH_REQ) ? RQ_SH : RQ_EX;
              end else if (cur_opc == OP_SH_REQ) begin
                out_dst_o = cur_src; dir_d[cid] = 1'b1;
              end else if (!h_ex_q) begin
                out_opc_o = OP_EX_REQ; out_dst_o = PARENT;
                busy_d = 1'b1; rq_type_d = RQ_EX; rq_id_d = cur_src;
              end else begin
                out_opc_o = OP_EX_REP; out_dst_o = cur_src;
                v_wr_d = 1'b1; owner_d = cid; dir_d = '0;
              end
            end
          end
          OP_WB_REP: begin
            if (busy_q && v_wr_q && is_child && cid == owner_q) begin
              push_o = 1'b1; out_data_o = head_data_i;
              value_d = head_data_i; busy_d = 1'b0;
              case (rq_type_q)
                RQ_SH: begin
                  out_opc_o = OP_SH_REP; out_dst_o = rq_id_q; v_wr_d = 1'b0;
                  dir_d = '0; dir_d[cid] = 1'b1; dir_d[rq_id_q[CID_W-1:0]] = 1'b1;
                end
                RQ_EX: begin
                  out_opc_o = OP_EX_REP; out_dst_o = rq_id_q;
                  owner_d = rq_id_q[CID_W-1:0]; dir_d = '0;
                end
                default: begin
                  out_opc_o = OP_WB_REP; out_dst_o = PARENT; v_wr_d = 1'b0;
                  h_ex_d = 1'b0; dir_d = '0; dir_d[cid] = 1'b1;
                end
              endcase
            end
          end
          OP_EX_REP: begin
            if (busy_q && rq_type_q == RQ_EX && !h_ex_q && cur_src == PARENT) begin
              push_o = 1'b1; out_opc_o = OP_EX_REP; out_dst_o = rq_id_q;
              out_data_o = head_data_i; value_d = head_data_i;
              h_ex_d = 1'b1; v_wr_d = 1'b1; owner_d = rq_id_q[CID_W-1:0];
              dir_d = '0; busy_d = 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (take && !use_park) pop_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_ex_q <= 1'b0; v_wr_q <= 1'b0; busy_q <= 1'b0;
      dir_q <= '0; owner_q <= '0; value_q <= '0;
      rq_type_q <= RQ_SH; rq_id_q <= '0;
      park_v_q <= 1'b0; park_opc_q <= '0; park_src_q <= '0;
    end else begin
      h_ex_q <= h_ex_d; v_wr_q <= v_wr_d; busy_q <= busy_d;
      dir_q <= dir_d; owner_q <= owner_d; value_q <= value_d;
      rq_type_q <= rq_type_d; rq_id_q <= rq_id_d;
      park_v_q <= park_v_d; park_opc_q <= park_opc_d; park_src_q <= park_src_d;
    end
  end

  assign h_ex_o  = h_ex_q;
  assign v_wr_o  = v_wr_q;
  assign dir_o   = dir_q;
  assign owner_o = owner_q;
  assign value_o = value_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/hcn_node.sv
module hcn_node #(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter int                N_CHILD    = 4,
  parameter int                FIFO_DEPTH = 4,
  parameter logic [ADDR_W-1:0] LINE_ADDR  = 'h40,
  parameter int                NODE_ID    = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [2:0]                 in_opc_i,
  input  logic [$clog2(N_CHILD):0]   in_src_i,
  input  logic [$clog2(N_CHILD):0]   in_dst_i,
  input  logic [ADDR_W-1:0]          in_addr_i,
  input  logic [DATA_W-1:0]          in_data_i,
  output logic                       out_valid_o,
  input  logic                       out_ready_i,
  output logic [2:0]                 out_opc_o,
  output logic [$clog2(N_CHILD):0]   out_src_o,
  output logic [$clog2(N_CHILD):0]   out_dst_o,
  output logic [ADDR_W-1:0]          out_addr_o,
  output logic [DATA_W-1:0]          out_data_o,
  output logic                       h_ex_o,
  output logic                       v_wr_o,
  output logic [N_CHILD-1:0]         dir_o,
  output logic [$clog2(N_CHILD)-1:0] owner_o,
  output logic [DATA_W-1:0]          value_o,
  output logic                       busy_o
);
  localparam int ID_W  = $clog2(N_CHILD) + 1;
  localparam int MSG_W = 3 + 2 * ID_W + ADDR_W + DATA_W;

  logic [MSG_W-1:0]  in_w, head_w, out_w, tail_w;
  logic              in_full, in_empty, out_full, out_empty, pop, push;
  logic [2:0]        h_opc, e_opc;
  logic [ID_W-1:0]   h_src, h_dst, e_dst;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data, e_data;

  assign in_w = {in_opc_i, in_src_i, in_dst_i, in_addr_i, in_data_i};
  assign in_ready_o = !in_full;
  assign {h_opc, h_src, h_dst, h_addr, h_data} = head_w;

  hcn_msg_fifo #(.W(MSG_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
    .clk_i, .rst_ni,
    .push_i(in_valid_i), .wdata_i(in_w), .full_o(in_full),
    .pop_i(pop), .rdata_o(head_w), .empty_o(in_empty)
  );

  hcn_coh_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CHILD(N_CHILD),
    .LINE_ADDR(LINE_ADDR), .NODE_ID(NODE_ID)
  ) u_engine (
    .clk_i, .rst_ni,
    .head_v_i(!in_empty), .head_opc_i(h_opc), .head_src_i(h_src),
    .head_dst_i(h_dst), .head_addr_i(h_addr), .head_data_i(h_data),
    .pop_o(pop), .out_full_i(out_full), .push_o(push),
    .out_opc_o(e_opc), .out_dst_o(e_dst), .out_data_o(e_data),
    .h_ex_o, .v_wr_o, .dir_o, .owner_o, .value_o, .busy_o
  );

  assign out_w = {e_opc, ID_W'(NODE_ID), e_dst, LINE_ADDR, e_data};

  hcn_msg_fifo #(.W(MSG_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .wdata_i(out_w), .full_o(out_full),
    .pop_i(out_ready_i), .rdata_o(tail_w), .empty_o(out_empty)
  );

  assign out_valid_o = !out_empty;
  assign {out_opc_o, out_src_o, out_dst_o, out_addr_o, out_data_o} = tail_w;
endmodule

// File: rtl/hcn_node_chk.sv
module hcn_node_chk #(
  parameter int N_CHILD = 4,
  parameter int DATA_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               out_valid_o,
  input logic               busy_o,
  input logic               h_ex_o,
  input logic               v_wr_o,
  input logic [N_CHILD-1:0] dir_o,
  input logic [DATA_W-1:0]  value_o
);
  a_r5_busy_rise_sends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> out_valid_o);

  a_r6_busy_fall_replies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> out_valid_o);

  a_r4_write_mode_no_sharers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_wr_o |-> (dir_o == '0));

  a_r3_write_mode_needs_ex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_wr_o |-> h_ex_o);

  a_r10_value_only_on_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(value_o) |-> $past(busy_o));
endmodule

bind hcn_node hcn_node_chk #(.N_CHILD(N_CHILD), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .out_valid_o(out_valid_o), .busy_o(busy_o),
  .h_ex_o(h_ex_o), .v_wr_o(v_wr_o), .dir_o(dir_o), .value_o(value_o)
);

// File: tb/hcn_node_tb.sv
module hcn_node_tb;
  localparam logic [2:0] SHQ = 3'd0, EXQ = 3'd1, WBQ = 3'd2, WBP = 3'd3, SHP = 3'd4, EXP = 3'd5;
  localparam logic [2:0] PAR = 3'd4, NID = 3'd5;
  localparam logic [7:0] LA  = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [2:0] in_opc = '0, in_src = '0, in_dst = '0;
  logic [7:0] in_addr = '0, in_data = '0;
  logic in_ready, out_valid, h_ex, v_wr, busy;
  logic [2:0] out_opc, out_src, out_dst;
  logic [7:0] out_addr, out_data, value;
  logic [3:0] dir;
  logic [1:0] owner;

  int n_chk = 0, n_bad = 0;
  logic [13:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  hcn_node u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_opc_i(in_opc), .in_src_i(in_src),
    .in_dst_i(in_dst), .in_addr_i(in_addr), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_opc_o(out_opc),
    .out_src_o(out_src), .out_dst_o(out_dst), .out_addr_o(out_addr), .out_data_o(out_data),
    .h_ex_o(h_ex), .v_wr_o(v_wr), .dir_o(dir), .owner_o(owner), .value_o(value), .busy_o(busy)
  );

  // monitor: pops expected messages in production order
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11 unexpected message act=%h exp=none", {out_opc, out_dst, out_data});
      end else begin
        logic [13:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_opc, out_dst, out_data} != e || out_src != NID || out_addr != LA) begin
          n_bad++;
          $display("FAIL %s/R12 act=%h src=%0d addr=%h exp=%h src=5 addr=40",
                   t, {out_opc, out_dst, out_data}, out_src, out_addr, e);
        end
      end
    end
  end

  task automatic expect_msg(input logic [2:0] opc, input logic [2:0] dst,
                            input logic [7:0] data, input string tag);
    exp_q.push_back({opc, dst, data});
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [2:0] opc, input logic [2:0] src,
                      input logic [7:0] data, input logic [7:0] addr = LA,
                      input logic [2:0] dst = NID);
    @(negedge clk);
    in_valid = 1'b1; in_opc = opc; in_src = src; in_data = data; in_addr = addr; in_dst = dst;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic chk_state(input string tag, input logic ex, input logic wr,
                           input logic [3:0] d, input logic [1:0] own,
                           input logic [7:0] val, input logic bz);
    n_chk++;
    if ({h_ex, v_wr, dir, owner, value, busy} != {ex, wr, d, own, val, bz}) begin
      n_bad++;
      $display("FAIL %s state act=%b/%b/%b/%0d/%h/%b exp=%b/%b/%b/%0d/%h/%b", tag,
               h_ex, v_wr, dir, owner, value, busy, ex, wr, d, own, val, bz);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_state("R1", 1'b0, 1'b0, 4'b0000, 2'd0, 8'h00, 1'b0);
    n_chk++;
    if (out_valid) begin n_bad++; $display("FAIL R1 out_valid act=1 exp=0"); end
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1", 1'b0, 1'b0, 4'b0000, 2'd0, 8'h00, 1'b0);

    // R2: read misses in read mode
    expect_msg(SHP, 3'd0, 8'h00, "R2"); send(SHQ, 3'd0, 8'h00);
    expect_msg(SHP, 3'd2, 8'h00, "R2"); send(SHQ, 3'd2, 8'h00);
    settle();
    chk_state("R2", 1'b0, 1'b0, 4'b0101, 2'd0, 8'h00, 1'b0);

    // R3: write miss while shared goes to parent
    expect_msg(EXQ, PAR, 8'h00, "R3"); send(EXQ, 3'd1, 8'h00);
    settle();
    chk_state("R3", 1'b0, 1'b0, 4'b0101, 2'd0, 8'h00, 1'b1);

    // R9: request while busy is held
    send(SHQ, 3'd3, 8'h00);
    settle();
    chk_state("R9", 1'b0, 1'b0, 4'b0101, 2'd0, 8'h00, 1'b1);

    // R3 grant, then parked R9 request recalls from new owner (R5)
    expect_msg(EXP, 3'd1, 8'hA5, "R3");
    expect_msg(WBQ, 3'd1, 8'hA5, "R9");
    send(EXP, PAR, 8'hA5);
    settle();
    chk_state("R5", 1'b1, 1'b1, 4'b0000, 2'd1, 8'hA5, 1'b1);

    // R6: writeback completes pending read
    expect_msg(SHP, 3'd3, 8'h3C, "R6"); send(WBP, 3'd1, 8'h3C);
    settle();
    chk_state("R6", 1'b1, 1'b0, 4'b1010, 2'd1, 8'h3C, 1'b0);

    // R4: local exclusive grant
    expect_msg(EXP, 3'd2, 8'h3C, "R4"); send(EXQ, 3'd2, 8'h00);
    settle();
    chk_state("R4", 1'b1, 1'b1, 4'b0000, 2'd2, 8'h3C, 1'b0);

    // R5 + R7: write miss against owner
    expect_msg(WBQ, 3'd2, 8'h3C, "R5"); send(EXQ, 3'd0, 8'h00);
    settle();
    chk_state("R5", 1'b1, 1'b1, 4'b0000, 2'd2, 8'h3C, 1'b1);
    expect_msg(EXP, 3'd0, 8'h77, "R7"); send(WBP, 3'd2, 8'h77);
    settle();
    chk_state("R7", 1'b1, 1'b1, 4'b0000, 2'd0, 8'h77, 1'b0);

    // R10: ignored messages
    send(SHQ, 3'd1, 8'h00, 8'h41);
    send(SHQ, 3'd1, 8'h00, LA, 3'd3);
    send(WBP, 3'd3, 8'h99);
    send(SHP, PAR, 8'h55);
    send(EXP, PAR, 8'h66);
    settle();
    chk_state("R10", 1'b1, 1'b1, 4'b0000, 2'd0, 8'h77, 1'b0);

    // R8: parent recall in write mode, then in read mode
    expect_msg(WBQ, 3'd0, 8'h77, "R8"); send(WBQ, PAR, 8'h00);
    settle();
    chk_state("R8", 1'b1, 1'b1, 4'b0000, 2'd0, 8'h77, 1'b1);
    expect_msg(WBP, PAR, 8'h12, "R8"); send(WBP, 3'd0, 8'h12);
    settle();
    chk_state("R8", 1'b0, 1'b0, 4'b0001, 2'd0, 8'h12, 1'b0);
    expect_msg(WBP, PAR, 8'h12, "R8"); send(WBQ, PAR, 8'h00);
    settle();
    chk_state("R8", 1'b0, 1'b0, 4'b0001, 2'd0, 8'h12, 1'b0);

    // R11: burst under backpressure
    out_ready = 1'b0;
    expect_msg(SHP, 3'd1, 8'h12, "R11"); send(SHQ, 3'd1, 8'h00);
    expect_msg(SHP, 3'd2, 8'h12, "R11"); send(SHQ, 3'd2, 8'h00);
    expect_msg(SHP, 3'd3, 8'h12, "R11"); send(SHQ, 3'd3, 8'h00);
    expect_msg(SHP, 3'd0, 8'h12, "R11"); send(SHQ, 3'd0, 8'h00);
    expect_msg(SHP, 3'd1, 8'h12, "R11"); send(SHQ, 3'd1, 8'h00);
    settle();
    n_chk++;
    if (!out_valid) begin n_bad++; $display("FAIL R11 out_valid act=0 exp=1"); end
    out_ready = 1'b1;
    settle();
    chk_state("R11", 1'b0, 1'b0, 4'b1111, 2'd0, 8'h12, 1'b0);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 pending act=%0d exp=0", exp_q.size());
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule